// File: doc/BRIEF.md
# DDR2 Self-Refresh Sequencer

This controller-side block takes a DDR2 device into self-refresh and brings it back out. A host pulses a request to enter and, later, a request to leave. The block drives the four command strobes, the clock-enable pin and the termination-enable pin, all of them from registers. It reports through a ready flag when ordinary commands may be issued again. Every minimum interval is a parameter counted in controller clock cycles: minimum residency `T_CKE`, the exit-to-first-command gap `T_XSNR`, the full exit settling time `T_XSRD`, and the refresh cycle time `T_RFC`.

The block keeps a record of whether the device has left self-refresh since its last refresh. If it has, a new entry request first issues one auto-refresh and waits `T_RFC` cycles before it issues the entry command. An entry request can also arrive during the exit period, once `T_XSNR` has passed. In that case the block goes straight to that refresh and re-entry, and does not wait out the rest of `T_XSRD`. A request that arrives in a state that cannot act on it is dropped. It is not stored.

Top module: `dram_selfref_seq`

## Requirements
- R1: While `rst` is high the outputs are `cke`=1, `odt`=0, `ready`=1 and a no-operation command on the strobes. The command encoding {cs_n,ras_n,cas_n,we_n} is no-operation 0111, deselect 1111, and refresh/self-refresh-entry 0001.
- R2: `enter_req` sampled in the idle state, with no refresh owed, gives one cycle of no-operation with `odt`=0 and `ready`=0. The cycle after that carries the entry command: strobes 0001 with `cke`=0.
- R3: `odt` is 0 in the cycle before the entry command, and it stays 0 for as long as `cke` is 0.
- R4: During residency the strobes carry deselect (1111) and `cke` stays 0. `cke` stays low for at least `T_CKE` cycles, counting the entry-command cycle.
- R5: Exit is taken only at an edge that samples `exit_req` and `clk_stable` both high, once the residency minimum has been met. `cke` rises at that same edge. Without `clk_stable`, the device stays in residency.
- R6: For the first `T_XSNR` cycles with `cke` high after an exit, the strobes carry no-operation.
- R7: `cke` stays 1 and `odt` stays 0 for the first `T_XSRD` cycles after an exit, whatever `odt_req` does, unless a re-entry is started.
- R8: After an exit without re-entry, `ready` returns to 1 in cycle max(`T_XSNR`,`T_XSRD`)+1 after `cke` rises. `ready` is 0 from the first cycle of any entry or refresh sequence until that point.
- R9: After any exit, the next entry is preceded by one refresh command (strobes 0001 with `cke`=1). That refresh is followed by `T_RFC`-1 no-operation cycles, and then the entry command.
- R10: In the exit period, `enter_req` is dropped until the `T_XSNR` window has elapsed. From the `T_XSNR`-th cycle on, it starts the R9 sequence at the next edge.
- R11: `exit_req` outside residency and `enter_req` during residency have no effect on any output.
- R12: In the idle state, `odt` follows `odt_req` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| enter_req | input | 1 | Request to enter self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | The memory clock is running and stable |
| odt_req | input | 1 | Termination wanted during normal operation |
| cs_n | output | 1 | Chip select strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write-enable strobe, active low |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination enable |
| ready | output | 1 | Normal commands may be issued |

## Verification
Every output comes from a register loaded from the next state. A request sampled at one edge therefore shows up on the pins right after that same edge. The exit timing follows from that: `cke` rises at the accepting edge, the first non-no-operation command can appear at cycle `T_XSNR`+1, and `ready` returns at cycle max(`T_XSNR`,`T_XSRD`)+1. The refresh-to-entry gap is exactly `T_RFC` edges. The bench's driver pushes, at each falling edge, the pin vector the requirements predict for after the coming rising edge. The monitor pops and compares that vector 2 ns after the rising edge, so each check lands in the one cycle it describes. Residency and the exit windows are run at their exact minimums as well as past them.

// File: rtl/dram_sr_pkg.sv
package dram_sr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ODTOFF = 3'd1,
    ST_ENTER  = 3'd2,
    ST_RESIDE = 3'd3,
    ST_EXITW  = 3'd4,
    ST_REFCMD = 3'd5,
    ST_REFW   = 3'd6
  } sr_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_DES = 4'b1111;
  localparam logic [3:0] CMD_REF = 4'b0001;

  typedef struct packed {
    logic       ready;
    logic       cke;
    logic       odt;
    logic [3:0] cmd;
  } pin_vec_t;

  localparam pin_vec_t PINS_RESET = '{ready: 1'b1, cke: 1'b1, odt: 1'b0, cmd: CMD_NOP};

endpackage

// File: rtl/sr_interval_timer.sv
module sr_interval_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                remain_q <= '0;
    else if (load)          remain_q <= load_val;
    else if (remain_q != 0) remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/sr_pin_reg.sv
module sr_pin_reg
  import dram_sr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sr_state_e state_d,
  input  logic      odt_req,
  output pin_vec_t  pins_q
);

  pin_vec_t pins_d;

  always_comb begin
    pins_d = '{ready: 1'b0, cke: 1'b1, odt: 1'b0, cmd: CMD_NOP};
    case (state_d)
      ST_IDLE: begin
        pins_d.ready = 1'b1;
        pins_d.odt   = odt_req;
      end
      ST_ENTER: begin
        pins_d.cke = 1'b0;
        pins_d.cmd = CMD_REF;
      end
      ST_RESIDE: begin
        pins_d.cke = 1'b0;
        pins_d.cmd = CMD_DES;
      end
      ST_REFCMD: pins_d.cmd = CMD_REF;
      default:   pins_d.cmd = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_RESET;
    else     pins_q <= pins_d;
  end

endmodule

// File: rtl/dram_selfref_seq.sv
module dram_selfref_seq
  import dram_sr_pkg::*;
#(
  parameter int T_CKE  = 5,
  parameter int T_XSNR = 4,
  parameter int T_XSRD = 7,
  parameter int T_RFC  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enter_req,
  input  logic exit_req,
  input  logic clk_stable,
  input  logic odt_req,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cke,
  output logic odt,
  output logic ready
);

  localparam int M1   = (T_CKE > T_XSNR) ? T_CKE : T_XSNR;
  localparam int M2   = (T_XSRD > T_RFC) ? T_XSRD : T_RFC;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int NTMR = 2;  // 0: shared interval timer, 1: exit settling timer

  sr_state_e state_q, state_d;
  logic      ref_owed_q;
  logic [NTMR-1:0]   tmr_load, tmr_done;
  logic [CW-1:0]     tmr_val [NTMR];
  pin_vec_t          pins_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (enter_req) state_d = ref_owed_q ? ST_REFCMD : ST_ODTOFF;
      ST_ODTOFF: state_d = ST_ENTER;
      ST_ENTER:  state_d = ST_RESIDE;
      ST_RESIDE: if (tmr_done[0] && exit_req && clk_stable) state_d = ST_EXITW;
      ST_EXITW: begin
        if (tmr_done[0] && enter_req)        state_d = ST_REFCMD;
        else if (tmr_done[0] && tmr_done[1]) state_d = ST_IDLE;
      end
      ST_REFCMD: state_d = ST_REFW;
      ST_REFW:   if (tmr_done[0]) state_d = ST_ENTER;
      default:   state_d = ST_IDLE;
    endcase
  end

  // timer loads on state entry
  always_comb begin
    tmr_load   = '0;
    tmr_val[0] = '0;
    tmr_val[1] = CW'(T_XSRD - 1);
    if (state_d != state_q) begin
      case (state_d)
        ST_ENTER: begin
          tmr_load[0] = 1'b1;
          tmr_val[0]  = CW'(T_CKE - 1);
        end
        ST_EXITW: begin
          tmr_load    = '1;
          tmr_val[0]  = CW'(T_XSNR - 1);
        end
        ST_REFCMD: begin
          tmr_load[0] = 1'b1;
          tmr_val[0]  = CW'(T_RFC - 1);
        end
        default: tmr_load = '0;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
      sr_interval_timer #(.W(CW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load[g]),
        .load_val(tmr_val[g]),
        .expired (tmr_done[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ref_owed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RESIDE && state_d == ST_EXITW) ref_owed_q <= 1'b1;
      else if (state_d == ST_REFCMD)                    ref_owed_q <= 1'b0;
    end
  end

  sr_pin_reg u_pins (
    .clk    (clk),
    .rst    (rst),
    .state_d(state_d),
    .odt_req(odt_req),
    .pins_q (pins_q)
  );

  assign {cs_n, ras_n, cas_n, we_n} = pins_q.cmd;
  assign cke   = pins_q.cke;
  assign odt   = pins_q.odt;
  assign ready = pins_q.ready;

endmodule

// File: rtl/dram_selfref_seq_chk.sv
module dram_selfref_seq_chk #(
  parameter int T_CKE  = 5,
  parameter int T_XSNR = 4,
  parameter int T_XSRD = 7,
  parameter int T_RFC  = 3
) (
  input logic clk,
  input logic rst,
  input logic exit_req,
  input logic clk_stable,
  input logic odt_req,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic odt,
  input logic ready
);

  localparam int XMAX = (T_XSNR > T_XSRD) ? T_XSNR : T_XSRD;
  localparam int M1   = (T_CKE > T_RFC) ? T_CKE : T_RFC;
  localparam int TOP  = (XMAX > M1) ? XMAX : M1;
  localparam int KW   = $clog2(TOP + 2) + 1;
  localparam logic [KW-1:0] SAT = '1;

  logic [3:0]    cmd;
  logic [KW-1:0] low_cnt, hi_cnt, ref_gap;
  logic          owe_ref, after_exit;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt    <= '0;
      hi_cnt     <= '0;
      ref_gap    <= SAT;
      owe_ref    <= 1'b0;
      after_exit <= 1'b0;
    end else begin
      if (!cke) begin
        if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
        hi_cnt     <= '0;
        owe_ref    <= 1'b1;
        after_exit <= 1'b1;
      end else begin
        low_cnt <= '0;
        if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
        if (cmd == 4'b0001) owe_ref <= 1'b0;
        if (ready) after_exit <= 1'b0;
      end
      if (cke && cmd == 4'b0001) ref_gap <= KW'(1);
      else if (ref_gap != SAT)    ref_gap <= ref_gap + 1'b1;
    end
  end

  AST_ENTRY_ENCODING: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> cmd == 4'b0001); // R2
  AST_ODT_OFF_BEFORE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> !$past(odt)); // R3
  AST_ODT_LOW_IN_RESIDENCY: assert property (@(posedge clk) disable iff (rst)
    !cke |-> !odt); // R3
  AST_MIN_RESIDENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> low_cnt >= KW'(T_CKE)); // R4
  AST_DESELECT_IN_RESIDENCY: assert property (@(posedge clk) disable iff (rst)
    (!cke && !$fell(cke)) |-> cs_n); // R4
  AST_EXIT_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> ($past(clk_stable) && $past(exit_req))); // R5
  AST_NOP_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (cke && after_exit && hi_cnt < KW'(T_XSNR)) |-> cmd == 4'b0111); // R6
  AST_ODT_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    (cke && after_exit && hi_cnt < KW'(T_XSRD)) |-> !odt); // R7
  AST_READY_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> hi_cnt >= KW'(XMAX)); // R8
  AST_REFRESH_BEFORE_REENTRY: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> !owe_ref); // R9
  AST_RFC_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> ref_gap >= KW'(T_RFC)); // R9
  AST_IDLE_ODT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> odt == $past(odt_req)); // R12

endmodule

bind dram_selfref_seq dram_selfref_seq_chk #(
  .T_CKE(T_CKE), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst(rst), .exit_req(exit_req), .clk_stable(clk_stable),
  .odt_req(odt_req), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .cke(cke), .odt(odt), .ready(ready)
);

// File: tb/dram_selfref_seq_tb.sv
`timescale 1ns/1ps
module dram_selfref_seq_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enter_req = 1'b0, exit_req = 1'b0, clk_stable = 1'b0, odt_req = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, odt, ready;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [6:0] q_exp[$];
  string      q_tag[$];

  // {ready, cke, odt, cs_n, ras_n, cas_n, we_n}
  localparam logic [6:0] IDLE1 = 7'b111_0111;
  localparam logic [6:0] IDLE0 = 7'b110_0111;
  localparam logic [6:0] QUIET = 7'b010_0111;  // not ready, cke high, odt low, NOP
  localparam logic [6:0] ENTRY = 7'b000_0001;
  localparam logic [6:0] HOLD  = 7'b000_1111;
  localparam logic [6:0] REFR  = 7'b010_0001;

  always #5 clk = ~clk;

  dram_selfref_seq #(.T_CKE(5), .T_XSNR(4), .T_XSRD(7), .T_RFC(3)) u_dut (
    .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
    .clk_stable(clk_stable), .odt_req(odt_req), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .odt(odt), .ready(ready)
  );

  function automatic logic [6:0] pins();
    return {ready, cke, odt, cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic check(input logic [6:0] e, input string t);
    n_chk++;
    if (pins() !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, pins(), e);
    end
  endtask

  // driver: inputs for the coming edge, and the pins expected after it
  task automatic cyc(input logic en, input logic ex, input logic st, input logic oq,
                     input logic [6:0] e, input string t);
    @(negedge clk);
    enter_req = en; exit_req = ex; clk_stable = st; odt_req = oq;
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) check(q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    odt_req = 1'b1;
    check(IDLE0, "R1 reset state");
    rst = 1'b0;

    cyc(0, 0, 1, 1, IDLE1, "R12 odt follows request");
    cyc(0, 1, 1, 1, IDLE1, "R11 exit ignored when idle");
    cyc(1, 0, 1, 1, QUIET, "R2 odt off before entry");
    cyc(0, 0, 1, 1, ENTRY, "R2 entry command");
    cyc(0, 1, 1, 1, HOLD,  "R4 early exit ignored");
    cyc(1, 1, 1, 1, HOLD,  "R11 enter ignored in residency");
    cyc(0, 1, 1, 1, HOLD,  "R4 residency hold");
    cyc(0, 1, 1, 1, HOLD,  "R4 residency hold");
    cyc(0, 1, 0, 1, HOLD,  "R5 no exit without stable clock");
    cyc(0, 1, 1, 1, QUIET, "R5 exit raises cke");
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, QUIET, "R10 enter ignored inside tXSNR");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, QUIET, "R7 odt held off in tXSRD");
    cyc(0, 0, 1, 1, IDLE1, "R8 ready after exit period");

    cyc(1, 0, 1, 1, REFR,  "R9 refresh owed before entry");
    cyc(0, 0, 1, 1, QUIET, "R9 nop during tRFC");
    cyc(0, 0, 1, 1, QUIET, "R9 nop during tRFC");
    cyc(0, 0, 1, 1, ENTRY, "R9 entry after tRFC");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, HOLD, "R4 minimum residency");
    cyc(0, 1, 1, 0, QUIET, "R4 exit at exactly tCKE");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, QUIET, "R6 nop window");
    cyc(1, 0, 1, 0, REFR,  "R10 re-entry once tXSNR elapsed");
    cyc(0, 0, 1, 0, QUIET, "R9 nop during tRFC");
    cyc(0, 0, 1, 0, QUIET, "R9 nop during tRFC");
    cyc(0, 0, 1, 0, ENTRY, "R9 re-entry command");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, HOLD, "R5 stays in residency without request");
    cyc(0, 1, 1, 0, QUIET, "R5 exit accepted");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1, QUIET, "R7 odt held off in tXSRD");
    cyc(0, 0, 1, 0, IDLE0, "R8 ready after exit period");
    cyc(0, 0, 1, 1, IDLE1, "R12 odt follows one cycle later");
    cyc(0, 0, 1, 0, IDLE0, "R12 odt drops one cycle later");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule